// File: doc/BRIEF.md
# Pulse Demodulation Capture

This block times the high and low phases of a single alternating digital input. When demodulation is switched on, the input, after synchronisation, gates the count of timer A and raises event A on each rising edge. Its inverse gates the count of timer B and raises event B on each falling edge. Software can then compare the two counts to obtain the width of each phase. The input is assumed to be already clean; it needs no hysteresis stage here.

With demodulation on, the dedicated count-gate pins of both timers and the event B pin have no effect, so the system can reuse them as general-purpose I/O. The level of the sensed input also appears in the top bit of the GPIO read-back word, as if it were an ordinary GPIO pin. With demodulation off, each timer counts on its own gate pin, event B follows rising edges of its own pin, and the read-back bit follows its GPIO pin.

Top module: `pulse_demod_capture`

## Requirements
- R1: While reset is held, both counts, both event strobes and the whole GPIO read-back word are zero.
- R2: With demodulation on, the timer A count rises by exactly one per clock cycle during which the sensed input is high, so a high phase of N cycles adds N.
- R3: With demodulation on, the timer B count rises by exactly one per clock cycle during which the sensed input is low, so a low phase of N cycles adds N.
- R4: In both modes, event A is a strobe one cycle wide on every low-to-high transition of the sensed input.
- R5: With demodulation on, event B is a strobe one cycle wide on every high-to-low transition of the sensed input.
- R6: With demodulation on, the timer A gate pin, the timer B gate pin and the event B pin change neither count and cause no event.
- R7: With demodulation on, read-back bit GPIO_BIT (bit 31 by default) shows the sensed input level, and all other read-back bits show their GPIO pins.
- R8: With demodulation off, timer A counts cycles with its gate pin high, timer B counts cycles with its gate pin high, event B strobes on rising edges of the event B pin, and read-back bit GPIO_BIT shows its own GPIO pin.
- R9: A clear strobe sets its timer count to zero on the next clock edge, and it takes precedence over a count on that edge.
- R10: A count wraps from 2^CNT_W - 1 to zero.
- R11: Every pin input passes through a SYNC_STAGES-flop synchroniser (two by default), so the read-back and the event strobes respond to a pin change after the second clock edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| demod_en | input | 1 | Selects demodulation mode (static configuration) |
| sense_pin | input | 1 | Alternating input whose phases are timed; event A source in both modes |
| tmr_a_pin | input | 1 | Timer A count gate in normal mode |
| tmr_b_pin | input | 1 | Timer B count gate in normal mode |
| evt_b_pin | input | 1 | Event B source in normal mode |
| gpio_pin | input | GPIO_W | GPIO pad levels |
| clr_a | input | 1 | Timer A clear strobe |
| clr_b | input | 1 | Timer B clear strobe |
| cnt_a | output | CNT_W | Timer A count |
| cnt_b | output | CNT_W | Timer B count |
| evt_a | output | 1 | Event A strobe |
| evt_b | output | 1 | Event B strobe |
| gpio_rd | output | GPIO_W | Synchronised GPIO read-back word |

## Verification
The wrap of a 16-bit count is the hardest case to reach, because it takes a single high phase longer than 65 535 cycles. The bench holds the sensed input high for 65 539 cycles and expects a residue of three. Showing that the freed pins are ignored is the other awkward case, since a correct design leaves no trace. The bench clears both timers, toggles those pins while the sensed input stays low, and then checks that timer A still reads zero, timer B holds exactly the elapsed cycle count, and the event queue gains no entry. A clear that lands on a counting edge is tested by clearing timer A in the middle of a high phase.

// File: rtl/pdc_pkg.sv
`timescale 1ns/1ps
package pdc_pkg;
   // Control pins carried through the synchroniser alongside the GPIO word
   typedef struct packed {
      logic sense;
      logic tmr_a;
      logic tmr_b;
      logic evt_b;
   } pdc_ctl_t;

   localparam int unsigned PDC_CTL_W = $bits(pdc_ctl_t);
   localparam int unsigned PDC_NUM_TMR = 2;

   typedef enum logic {
      PDC_MODE_NORMAL = 1'b0,
      PDC_MODE_DEMOD  = 1'b1
   } pdc_mode_e;
endpackage

// File: rtl/pdc_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser chain, one per bit
module pdc_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pdc_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("pdc_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pdc_edge.sv
`timescale 1ns/1ps
// Single-cycle edge strobe; RISING selects which transition is reported
module pdc_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pulse
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   if (RISING) begin : g_rise
      assign pulse = lvl & ~lvl_q;
   end else begin : g_fall
      assign pulse = ~lvl & lvl_q;
   end
endmodule

// File: rtl/pdc_timer.sv
`timescale 1ns/1ps
// Gated up-counter with clear priority and natural wrap
module pdc_timer #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         gate,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   if (W < 2) begin : g_bad_w
      $error("pdc_timer: W must be at least 2");
   end

   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (gate) cnt <= cnt + ONE;
   end
endmodule

// File: rtl/pdc_route.sv
`timescale 1ns/1ps
// Mode-dependent selection of timer gates, event B source and read-back bit
module pdc_route
   import pdc_pkg::*;
#(
   parameter int unsigned NUM_TMR = PDC_NUM_TMR
) (
   input  pdc_mode_e          mode,
   input  pdc_ctl_t           s_ctl,
   input  logic               s_gpio_bit,
   input  logic               fall_sense,
   input  logic               rise_evtb,
   output logic [NUM_TMR-1:0] tmr_gate,
   output logic               evt_b,
   output logic               mirror_bit
);
   if (NUM_TMR != 2) begin : g_bad_num
      $error("pdc_route: exactly two timer channels are supported");
   end

   for (genvar c = 0; c < int'(NUM_TMR); c++) begin : g_gate
      if (c == 0) begin : g_true
         // Channel A: sensed level as-is, or its own pin
         assign tmr_gate[c] = (mode == PDC_MODE_DEMOD) ? s_ctl.sense : s_ctl.tmr_a;
      end else begin : g_inv
         // Channel B: inverted sensed level, or its own pin
         assign tmr_gate[c] = (mode == PDC_MODE_DEMOD) ? ~s_ctl.sense : s_ctl.tmr_b;
      end
   end

   // Strobes are muxed after detection so a mode change creates no edge
   assign evt_b      = (mode == PDC_MODE_DEMOD) ? fall_sense : rise_evtb;
   assign mirror_bit = (mode == PDC_MODE_DEMOD) ? s_ctl.sense : s_gpio_bit;
endmodule

// File: rtl/pulse_demod_capture.sv
`timescale 1ns/1ps
module pulse_demod_capture
   import pdc_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned GPIO_W      = 32,
   parameter int unsigned GPIO_BIT    = 31,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              demod_en,
   input  logic              sense_pin,
   input  logic              tmr_a_pin,
   input  logic              tmr_b_pin,
   input  logic              evt_b_pin,
   input  logic [GPIO_W-1:0] gpio_pin,
   input  logic              clr_a,
   input  logic              clr_b,
   output logic [CNT_W-1:0]  cnt_a,
   output logic [CNT_W-1:0]  cnt_b,
   output logic              evt_a,
   output logic              evt_b,
   output logic [GPIO_W-1:0] gpio_rd
);
   localparam int unsigned SYN_W = GPIO_W + PDC_CTL_W;

   if (GPIO_BIT >= GPIO_W) begin : g_bad_bit
      $error("pulse_demod_capture: GPIO_BIT out of range");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("pulse_demod_capture: CNT_W must be at least 2");
   end

   pdc_ctl_t          raw_ctl, s_ctl;
   logic [GPIO_W-1:0] s_gpio;
   logic [SYN_W-1:0]  syn_q;

   assign raw_ctl = '{sense: sense_pin, tmr_a: tmr_a_pin, tmr_b: tmr_b_pin, evt_b: evt_b_pin};

   pdc_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({raw_ctl, gpio_pin}),
      .q     (syn_q)
   );

   assign s_ctl  = syn_q[SYN_W-1 -: PDC_CTL_W];
   assign s_gpio = syn_q[GPIO_W-1:0];

   // Edge strobes on synchronised levels
   logic rise_sense, fall_sense, rise_evtb;

   pdc_edge #(.RISING(1'b1)) u_rise_sense (
      .clk(clk), .rst_n(rst_n), .lvl(s_ctl.sense), .pulse(rise_sense));
   pdc_edge #(.RISING(1'b0)) u_fall_sense (
      .clk(clk), .rst_n(rst_n), .lvl(s_ctl.sense), .pulse(fall_sense));
   pdc_edge #(.RISING(1'b1)) u_rise_evtb (
      .clk(clk), .rst_n(rst_n), .lvl(s_ctl.evt_b), .pulse(rise_evtb));

   // Routing
   pdc_mode_e                mode;
   logic [PDC_NUM_TMR-1:0]   tmr_gate;
   logic                     mirror_bit;

   assign mode = demod_en ? PDC_MODE_DEMOD : PDC_MODE_NORMAL;

   pdc_route #(.NUM_TMR(PDC_NUM_TMR)) u_route (
      .mode       (mode),
      .s_ctl      (s_ctl),
      .s_gpio_bit (s_gpio[GPIO_BIT]),
      .fall_sense (fall_sense),
      .rise_evtb  (rise_evtb),
      .tmr_gate   (tmr_gate),
      .evt_b      (evt_b),
      .mirror_bit (mirror_bit)
   );

   assign evt_a = rise_sense;

   // Timers
   logic [PDC_NUM_TMR-1:0] tmr_clr;
   logic [CNT_W-1:0]       tmr_cnt [PDC_NUM_TMR];

   assign tmr_clr = {clr_b, clr_a};

   for (genvar c = 0; c < int'(PDC_NUM_TMR); c++) begin : g_tmr
      pdc_timer #(.W(CNT_W)) u_tmr (
         .clk   (clk),
         .rst_n (rst_n),
         .gate  (tmr_gate[c]),
         .clr   (tmr_clr[c]),
         .cnt   (tmr_cnt[c])
      );
   end

   assign cnt_a = tmr_cnt[0];
   assign cnt_b = tmr_cnt[1];

   // Read-back word with the mirrored bit substituted
   always_comb begin
      gpio_rd           = s_gpio;
      gpio_rd[GPIO_BIT] = mirror_bit;
   end
endmodule

// File: rtl/pulse_demod_capture_chk.sv
`timescale 1ns/1ps
module pulse_demod_capture_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             demod_en,
   input logic             clr_a,
   input logic             clr_b,
   input logic [CNT_W-1:0] cnt_a,
   input logic [CNT_W-1:0] cnt_b,
   input logic             evt_a,
   input logic             evt_b,
   input logic             mirror
);
   // R4: event A lasts one cycle
   a_r4_evt_a_single: assert property (@(posedge clk) disable iff (!rst_n)
      evt_a |=> !evt_a);

   // R5: event B lasts one cycle
   a_r5_evt_b_single: assert property (@(posedge clk) disable iff (!rst_n)
      evt_b |=> !evt_b);

   // R5: in demodulation mode a rise and a fall cannot coincide
   a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      demod_en |-> !(evt_a && evt_b));

   // R7: mirrored bit agrees with the edge just reported
   a_r7_mirror_high: assert property (@(posedge clk) disable iff (!rst_n)
      (demod_en && evt_a) |-> mirror);
   a_r7_mirror_low: assert property (@(posedge clk) disable iff (!rst_n)
      (demod_en && evt_b) |-> !mirror);

   // R9: clear wins on the next edge
   a_r9_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
      clr_a |=> (cnt_a == '0));
   a_r9_clear_b: assert property (@(posedge clk) disable iff (!rst_n)
      clr_b |=> (cnt_b == '0));

   // R2/R10: without a clear, a count holds or steps by one (wrapping)
   a_r2_step_a: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_a |=> (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + CNT_W'(1)));
   // R3/R10: same for timer B
   a_r3_step_b: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_b |=> (cnt_b == $past(cnt_b) || cnt_b == $past(cnt_b) + CNT_W'(1)));

   // R2/R3: in demodulation mode the two timers never step together
   a_r3_not_both: assert property (@(posedge clk) disable iff (!rst_n)
      (demod_en && $past(demod_en) && !clr_a && !clr_b) |=>
      !(cnt_a != $past(cnt_a) && cnt_b != $past(cnt_b)));
endmodule

bind pulse_demod_capture pulse_demod_capture_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .demod_en (demod_en),
   .clr_a    (clr_a),
   .clr_b    (clr_b),
   .cnt_a    (cnt_a),
   .cnt_b    (cnt_b),
   .evt_a    (evt_a),
   .evt_b    (evt_b),
   .mirror   (gpio_rd[GPIO_BIT])
);

// File: tb/test_pulse_demod_capture.sv
`timescale 1ns/1ps
module test_pulse_demod_capture;
   localparam int CNT_W  = 16;
   localparam int GPIO_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              demod_en = 1'b1;
   logic              sense_pin = 1'b0, tmr_a_pin = 1'b0, tmr_b_pin = 1'b0, evt_b_pin = 1'b0;
   logic [GPIO_W-1:0] gpio_pin = '0;
   logic              clr_a = 1'b0, clr_b = 1'b0;
   logic [CNT_W-1:0]  cnt_a, cnt_b;
   logic              evt_a, evt_b;
   logic [GPIO_W-1:0] gpio_rd;

   int total = 0;
   int bad   = 0;
   int exp_q[$];   // 2 = event A, 4 = event B

   always #4 clk = ~clk;   // 125 MHz

   pulse_demod_capture i_pulse_demod_capture (
      .clk(clk), .rst_n(rst_n), .demod_en(demod_en), .sense_pin(sense_pin),
      .tmr_a_pin(tmr_a_pin), .tmr_b_pin(tmr_b_pin), .evt_b_pin(evt_b_pin),
      .gpio_pin(gpio_pin), .clr_a(clr_a), .clr_b(clr_b), .cnt_a(cnt_a),
      .cnt_b(cnt_b), .evt_a(evt_a), .evt_b(evt_b), .gpio_rd(gpio_rd));

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: pops expected events as the design raises them
   task automatic pop_cmp(input int code);
      if (exp_q.size() == 0) check(1'b0, "R4/R5 unexpected event", code, 0);
      else begin
         int e = exp_q.pop_front();
         check(e == code, "R4/R5 event order", code, e);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (evt_a) pop_cmp(2);
         if (evt_b) pop_cmp(4);
      end
   end

   // Driver helpers
   task automatic set_sense(input logic v);
      if (v && !sense_pin) exp_q.push_back(2);
      if (!v && sense_pin && demod_en) exp_q.push_back(4);
      sense_pin = v;
   endtask

   task automatic pulse_clr(input bit a, input bit b);
      clr_a = a; clr_b = b;
      tick(1);
      clr_a = 1'b0; clr_b = 1'b0;
   endtask

   task automatic measure(input int hi, input int lo);
      pulse_clr(1, 0);
      set_sense(1'b1); tick(hi); set_sense(1'b0); tick(4);
      check(cnt_a == CNT_W'(hi), "R2 high phase count", cnt_a, hi);
      set_sense(1'b1); tick(4);
      pulse_clr(0, 1);
      set_sense(1'b0); tick(lo); set_sense(1'b1); tick(4);
      check(cnt_b == CNT_W'(lo), "R3 low phase count", cnt_b, lo);
      set_sense(1'b0); tick(4);
   endtask

   // Watchdog
   initial begin
      repeat (190000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(3);
      // R1 reset state
      check(cnt_a == 0 && cnt_b == 0, "R1 counts in reset", {cnt_a, cnt_b}, 0);
      check(!evt_a && !evt_b, "R1 strobes in reset", {evt_a, evt_b}, 0);
      check(gpio_rd == 0, "R1 read-back in reset", gpio_rd, 0);
      rst_n = 1'b1;
      tick(4);

      // R11 latency of two edges, R4 strobe at that point
      set_sense(1'b1);
      tick(1);
      check(gpio_rd[31] == 1'b0, "R11 not visible after one edge", gpio_rd[31], 0);
      tick(1);
      check(gpio_rd[31] == 1'b1, "R11 visible after two edges", gpio_rd[31], 1);
      check(evt_a == 1'b1, "R4 strobe timing", evt_a, 1);
      tick(3);

      // R7 mirror in demod mode
      gpio_pin = 32'h0000_1234;
      tick(3);
      check(gpio_rd == 32'h8000_1234, "R7 mirror high", gpio_rd, 32'h8000_1234);
      set_sense(1'b0); tick(3);
      gpio_pin = 32'h8000_1234; tick(3);
      check(gpio_rd == 32'h0000_1234, "R7 mirror low", gpio_rd, 32'h0000_1234);
      gpio_pin = '0;

      // R2/R3/R4/R5 phase measurement, several patterns
      measure(5, 9);
      measure(1, 1);
      measure(12, 3);

      // R9 clear during counting
      set_sense(1'b1); tick(10);
      clr_a = 1'b1; tick(1); clr_a = 1'b0;
      check(cnt_a == 0, "R9 clear beats count", cnt_a, 0);
      tick(2);
      check(cnt_a == 2, "R9 counts resume", cnt_a, 2);
      set_sense(1'b0); tick(4);

      // R6 freed pins ignored in demod mode
      pulse_clr(1, 1);
      for (int i = 0; i < 20; i++) begin
         tmr_a_pin = i[0]; tmr_b_pin = ~i[0]; evt_b_pin = i[1];
         tick(1);
      end
      check(cnt_a == 0, "R6 timer A unaffected", cnt_a, 0);
      check(cnt_b == 20, "R6 timer B unaffected", cnt_b, 20);
      tmr_a_pin = 1'b0; tmr_b_pin = 1'b0; evt_b_pin = 1'b0;
      tick(4);

      // R10 wrap
      pulse_clr(1, 0);
      set_sense(1'b1); tick(65539); set_sense(1'b0); tick(4);
      check(cnt_a == 3, "R10 wrap residue", cnt_a, 3);

      // R8 normal mode
      demod_en = 1'b0; tick(4);
      pulse_clr(1, 1);
      tmr_a_pin = 1'b1; tick(7); tmr_a_pin = 1'b0;
      tmr_b_pin = 1'b1; tick(5); tmr_b_pin = 1'b0;
      tick(4);
      check(cnt_a == 7, "R8 timer A own pin", cnt_a, 7);
      check(cnt_b == 5, "R8 timer B own pin", cnt_b, 5);
      set_sense(1'b1); tick(4); set_sense(1'b0); tick(4);   // R4: no event B on fall
      exp_q.push_back(4); evt_b_pin = 1'b1; tick(4); evt_b_pin = 1'b0; tick(4);
      sense_pin = 1'b0;
      gpio_pin = 32'h8000_00A5; tick(3);
      check(gpio_rd == 32'h8000_00A5, "R8 read-back bit own pin", gpio_rd, 32'h8000_00A5);
      gpio_pin = 32'h0000_00A5; set_sense(1'b1); tick(3);
      check(gpio_rd == 32'h0000_00A5, "R8 sense not mirrored", gpio_rd, 32'h0000_00A5);
      tick(3);

      check(exp_q.size() == 0, "R4/R5 all expected events seen", exp_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule